// File: doc/BRIEF.md
# Path Remote Error Indication Monitor

This block sits on the receive path of an STS-1 payload and looks at the G1 path overhead byte once per received envelope. The far-end path terminating equipment reports in the upper nibble of G1 how many blocks it found in error. The block decodes that nibble. When the nibble carries a valid error report it raises a detection event and adds the reported number to a saturating error total. Software reads the total through a byte-wide register port.

The same port exposes an 8-bit path interrupt status byte and its enable mask. The status byte gathers the error-report detection together with six event pulses from neighbouring path defect logic. Each status bit is sticky and clears when software reads the byte. An active-low interrupt output stays low while any enabled status bit is set.

The G1 input is a valid/ready stream. The block accepts one byte on every cycle in which valid is high, and ready is always high, so it never applies back-pressure. Register reads return data one cycle after the request.

Top module: `path_rei_monitor`

## Requirements
- R1: The error field is G1 bits 7:4, where bit 7 is the most significant bit. A field value of 0, or any value from 9 to 15, causes no detection and leaves the total unchanged.
- R2: An accepted G1 byte whose field is between 1 and 8 sets status bit 6 at the next clock edge.
- R3: Each valid error report adds its field value, not 1, to the live error total.
- R4: The live total saturates at all ones and never wraps to a smaller value.
- R5: A read of the count least-significant byte (address 4) returns the live low byte and copies the whole live total into a holding register. The same read clears the live total. An error report accepted in the same cycle as this read is counted after the clear.
- R6: Reads of addresses 5, 6 and 7 return bytes 1, 2 and 3 of the holding register. Bytes above the counter width read as 0. Error reports that arrive after the latch do not change these reads.
- R7: Address 0 holds the status byte. Bits 5 to 0 are set by evt_in[5] to evt_in[0]: evt_in[5] is UNEQ change, [4] is PLM change, [3] is new C2, [2] is unstable-C2 change, [1] is RDI change and [0] is new RDI value. Bit 7 always reads 0.
- R8: A read of address 0 returns the status byte and then clears bits 6:0. A bit whose event arrives in the same cycle as that read is set after the read.
- R9: Address 1 holds the enable mask. Bits 6:0 are writable and bit 7 reads 0. The mask resets to 0. int_n is 0 exactly while some status bit and its mask bit are both 1.
- R10: g1_ready is 1 whenever the block is out of reset. rd_data is updated on the clock edge that samples rd_en, so it is valid one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| g1_valid | input | 1 | G1 byte present |
| g1_ready | output | 1 | Block accepts G1 (always 1) |
| g1_data | input | 8 | Received G1 byte |
| evt_in | input | 6 | Single-cycle path event pulses for status bits 5:0 |
| rd_en | input | 1 | Register read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, one cycle after request |
| wr_en | input | 1 | Register write request |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| int_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that evt_in carries single-cycle pulses and that g1_data is stable while g1_valid is high. They treat a read and a write of the mask as independent operations. The bench drives every input at the falling edge and holds each pulse for exactly one cycle. It deliberately places G1 bytes and event pulses in the same cycle as clearing reads, so that the collision rules are exercised under the same stimulus the properties assume. A second instance with an 8-bit counter reaches saturation within a short run.

// File: rtl/rei_pkg.sv
package rei_pkg;
  localparam int STS_ADDR   = 0;
  localparam int MASK_ADDR  = 1;
  localparam int CNT_BASE   = 4;
  localparam int STS_W      = 8;
  localparam int STS_REI    = 6;
  localparam int EVT_W      = 6;
  localparam int FIELD_HI   = 7;
  localparam int FIELD_LO   = 4;
  localparam int FIELD_W    = FIELD_HI - FIELD_LO + 1;
  localparam int FIELD_MAX  = 8;
  localparam int MAX_BYTES  = 4;
endpackage

// File: rtl/rei_extract.sv
module rei_extract
  import rei_pkg::*;
(
  input  logic               fire_i,
  input  logic [7:0]         g1_i,
  output logic               err_o,
  output logic [FIELD_W-1:0] amt_o
);
  logic [FIELD_W-1:0] field;

  always_comb begin
    field = g1_i[FIELD_HI:FIELD_LO];
    err_o = fire_i && (field != '0) && (field <= FIELD_W'(FIELD_MAX));
    amt_o = err_o ? field : '0;
  end
endmodule

// File: rtl/rei_err_counter.sv
module rei_err_counter
  import rei_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               add_en_i,
  input  logic [FIELD_W-1:0] add_val_i,
  input  logic               clr_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CNT_W-1:0]   hold_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, hold_q, base;
  logic [CNT_W:0]   sum;

  always_comb begin
    base = clr_i ? '0 : cnt_q;
    sum  = {1'b0, base} + (CNT_W+1)'(add_en_i ? add_val_i : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      cnt_q <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
      if (clr_i) hold_q <= cnt_q;
    end
  end

  assign cnt_o  = cnt_q;
  assign hold_o = hold_q;

  // R4: total only moves upward between clears
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> cnt_q >= $past(cnt_q));
  // R5: clear without concurrent report leaves zero
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !add_en_i) |=> cnt_q == '0);
  // R6: holding register only changes on a latch
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> $stable(hold_q));
  // R3: unsaturated accumulation adds the field value
  a_r3_adds_value: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en_i && !clr_i && cnt_q < CNT_MAX - CNT_W'(FIELD_MAX))
      |=> cnt_q == $past(cnt_q) + CNT_W'($past(add_val_i)));
endmodule

// File: rtl/path_int_status.sv
module path_int_status
  import rei_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_W-2:0] set_i,
  input  logic             rd_clr_i,
  input  logic             mask_we_i,
  input  logic [STS_W-1:0] mask_d_i,
  output logic [STS_W-1:0] sts_o,
  output logic [STS_W-1:0] mask_o,
  output logic             int_n_o
);
  logic [STS_W-2:0] sts_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= '0;
      mask_q <= '0;
    end else begin
      sts_q <= (rd_clr_i ? '0 : sts_q) | set_i;
      if (mask_we_i) mask_q <= mask_d_i[STS_W-2:0];
    end
  end

  assign sts_o   = {1'b0, sts_q};
  assign mask_o  = {1'b0, mask_q};
  assign int_n_o = ~|(sts_q & mask_q);

  for (genvar k = 0; k < STS_W-1; k++) begin : g_sticky
    // R8: an event always leaves its bit set, read or not
    a_r8_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> sts_q[k]);
    // R8: without read, a set bit stays set
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[k] && !rd_clr_i) |=> sts_q[k]);
  end
  // R8: a read with no new events empties the byte
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && set_i == '0) |=> sts_q == '0);
endmodule

// File: rtl/path_rei_monitor.sv
module path_rei_monitor
  import rei_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              g1_valid,
  output logic              g1_ready,
  input  logic [7:0]        g1_data,
  input  logic [EVT_W-1:0]  evt_in,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              int_n
);
  localparam int NBYTES = CNT_W / 8;

  logic               fire, rei_err, sts_rd, lsb_rd, mask_we;
  logic [FIELD_W-1:0] rei_amt;
  logic [CNT_W-1:0]   cnt, hold;
  logic [31:0]        cnt_pad, hold_pad;
  logic [STS_W-1:0]   sts, mask;
  logic [STS_W-2:0]   sts_set;
  logic [7:0]         rd_next, rd_q;

  assign g1_ready = 1'b1;
  assign fire     = g1_valid && g1_ready;
  assign sts_rd   = rd_en && (rd_addr == ADDR_W'(STS_ADDR));
  assign lsb_rd   = rd_en && (rd_addr == ADDR_W'(CNT_BASE));
  assign mask_we  = wr_en && (wr_addr == ADDR_W'(MASK_ADDR));
  assign sts_set  = {rei_err, evt_in};

  rei_extract u_extract (
    .fire_i (fire),
    .g1_i   (g1_data),
    .err_o  (rei_err),
    .amt_o  (rei_amt)
  );

  rei_err_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .add_en_i  (rei_err),
    .add_val_i (rei_amt),
    .clr_i     (lsb_rd),
    .cnt_o     (cnt),
    .hold_o    (hold)
  );

  path_int_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (sts_set),
    .rd_clr_i  (sts_rd),
    .mask_we_i (mask_we),
    .mask_d_i  (wr_data),
    .sts_o     (sts),
    .mask_o    (mask),
    .int_n_o   (int_n)
  );

  assign cnt_pad  = 32'(cnt);
  assign hold_pad = 32'(hold);

  always_comb begin
    rd_next = '0;
    if (rd_addr == ADDR_W'(STS_ADDR))  rd_next = sts;
    if (rd_addr == ADDR_W'(MASK_ADDR)) rd_next = mask;
    if (rd_addr == ADDR_W'(CNT_BASE))  rd_next = cnt_pad[7:0];
    for (int k = 1; k < MAX_BYTES; k++) begin
      if (k < NBYTES && rd_addr == ADDR_W'(CNT_BASE + k))
        rd_next = hold_pad[k*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_next;
  end

  assign rd_data = rd_q;

  // R1: out-of-range field never reports an error
  a_r1_field_range: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && g1_data[FIELD_HI:FIELD_LO] > FIELD_W'(FIELD_MAX)) |-> !rei_err);
  // R2: valid report shows up in status bit 6
  a_r2_sets_bit6: assert property (@(posedge clk) disable iff (!rst_n)
    rei_err |=> sts[STS_REI]);
  // R7: bit 7 of a status read is zero
  a_r7_bit7_read: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rd |=> !rd_data[7]);
  // R9: interrupt low only while an enabled bit is pending
  a_r9_int_source: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n |-> (sts & mask) != '0);
  // R10: stream never back-pressures
  a_r10_ready: assert property (@(posedge clk) disable iff (!rst_n)
    g1_valid |-> g1_ready);
endmodule

// File: tb/tb_path_rei_monitor.sv
module tb_path_rei_monitor;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n;
  logic       g1_valid, g1_ready, sat_ready;
  logic [7:0] g1_data;
  logic [5:0] evt_in;
  logic       rd_en, wr_en;
  logic [2:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data, sat_data;
  logic       int_n, sat_int_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  path_rei_monitor dut (
    .clk(clk), .rst_n(rst_n), .g1_valid(g1_valid), .g1_ready(g1_ready),
    .g1_data(g1_data), .evt_in(evt_in), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .int_n(int_n)
  );

  path_rei_monitor #(.CNT_W(8)) dut_sat (
    .clk(clk), .rst_n(rst_n), .g1_valid(g1_valid), .g1_ready(sat_ready),
    .g1_data(g1_data), .evt_in(evt_in), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(sat_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .int_n(sat_int_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send_g1(input logic [7:0] b);
    g1_valid = 1; g1_data = b;
    @(negedge clk);
    g1_valid = 0; g1_data = 0;
  endtask

  task automatic pulse_evt(input logic [5:0] e);
    evt_in = e;
    @(negedge clk);
    evt_in = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    d = rd_data;
    rd_en = 0;
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R10 ready", 32'(g1_ready), 1);
    check("R9 int_n reset", 32'(int_n), 1);
    reg_rd(0, d); check("R7 status reset", 32'(d), 0);
    reg_rd(1, d); check("R9 mask reset", 32'(d), 0);
    reg_rd(4, d); check("R5 count reset", 32'(d), 0);
  endtask

  task automatic t_no_error;
    logic [7:0] d;
    send_g1(8'h0F); send_g1(8'h9A); send_g1(8'hF0);
    reg_rd(0, d); check("R1 no detect", 32'(d), 0);
    reg_rd(4, d); check("R1 no count", 32'(d), 0);
  endtask

  task automatic t_accumulate;
    logic [7:0] d;
    send_g1(8'h35); send_g1(8'h80); send_g1(8'h1F);
    reg_rd(4, d); check("R3 sum of fields", 32'(d), 12);
    reg_rd(4, d); check("R5 cleared", 32'(d), 0);
    reg_rd(0, d); check("R2 bit6", 32'(d), 32'h40);
    reg_rd(0, d); check("R8 cleared", 32'(d), 0);
  endtask

  task automatic t_large_and_sat;
    logic [7:0] d;
    for (int i = 0; i < 40; i++) send_g1(8'h80);
    rd_en = 1; rd_addr = 4;
    @(negedge clk);
    check("R5 live lsb", 32'(rd_data), 32'h40);
    check("R4 saturated", 32'(sat_data), 32'hFF);
    rd_en = 0;
    send_g1(8'h20);
    reg_rd(5, d); check("R6 hold byte1", 32'(d), 32'h01);
    reg_rd(6, d); check("R6 hold byte2", 32'(d), 0);
    reg_rd(7, d); check("R6 hold byte3", 32'(d), 0);
    reg_rd(4, d); check("R5 after latch", 32'(d), 2);
  endtask

  task automatic t_clear_collision;
    logic [7:0] d;
    send_g1(8'h30);
    rd_en = 1; rd_addr = 4; g1_valid = 1; g1_data = 8'h50;
    @(negedge clk);
    check("R5 collision read", 32'(rd_data), 3);
    rd_en = 0; g1_valid = 0; g1_data = 0;
    reg_rd(4, d); check("R5 collision kept", 32'(d), 5);
    reg_rd(0, d);
  endtask

  task automatic t_events;
    logic [7:0] d;
    for (int k = 0; k < 6; k++) begin
      pulse_evt(6'(1 << k));
      reg_rd(0, d); check($sformatf("R7 event bit %0d", k), 32'(d), 32'(1 << k));
    end
    pulse_evt(6'h3F);
    reg_rd(0, d); check("R7 all events bit7 low", 32'(d), 32'h3F);
  endtask

  task automatic t_status_collision;
    logic [7:0] d;
    pulse_evt(6'h04);
    rd_en = 1; rd_addr = 0; evt_in = 6'h02;
    @(negedge clk);
    check("R8 collision read", 32'(rd_data), 32'h04);
    rd_en = 0; evt_in = 0;
    reg_rd(0, d); check("R8 collision kept", 32'(d), 32'h02);
  endtask

  task automatic t_mask_int;
    logic [7:0] d;
    send_g1(8'h10);
    check("R9 masked int", 32'(int_n), 1);
    reg_wr(1, 8'hFF);
    reg_rd(1, d); check("R9 mask readback", 32'(d), 32'h7F);
    check("R9 int low", 32'(int_n), 0);
    reg_wr(3, 8'h00);
    check("R9 other addr ignored", 32'(int_n), 0);
    reg_rd(0, d); check("R2 status", 32'(d), 32'h40);
    check("R9 int released", 32'(int_n), 1);
    reg_wr(1, 8'h01);
    pulse_evt(6'h02);
    check("R9 disabled bit", 32'(int_n), 1);
    pulse_evt(6'h01);
    check("R9 enabled bit", 32'(int_n), 0);
  endtask

  initial begin
    rst_n = 0; g1_valid = 0; g1_data = 0; evt_in = 0;
    rd_en = 0; rd_addr = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_no_error;
    t_accumulate;
    t_large_and_sat;
    t_clear_collision;
    t_events;
    t_status_collision;
    t_mask_int;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule